// File: doc/BRIEF.md
# Transition-Mode Boost Gate Timing Controller

This block decides, cycle by cycle, when the switch of a boost power-factor stage is on. It works in transition mode: a new on-time starts when the inductor current has fallen back to zero. All of its inputs are comparator outputs that are already digital and synchronous to the system clock. These inputs are the demagnetisation sense (an arming level and a trigger level), current sense against the sinusoidal reference, current sense against a higher saturation stop level, a dynamic over-voltage flag, a feedback-low flag and an enable from the system sequencer. All timing is counted in clock cycles.

A switching cycle starts on a falling demagnetisation edge, but only after the sense signal has first been armed. If no such edge arrives, a restart timer starts a cycle instead. This covers startup, when the inductor holds no energy. The timer is reloaded on every turn-on. After each turn-on the reference comparator is ignored for a blanking window. A maximum on-time counter limits the pulse if no turn-off ever comes. The saturation stop and the over-voltage flag each hold the gate off only while they are asserted. When both feedback-low and over-voltage are asserted, the block raises a feedback-disconnection flag, and the sequencer latches it.

Top module: `tm_boost_gate_ctl`

## Requirements
- R1: While `en_i` is low the gate is low from the next clock edge, and both timers are cleared. After `en_i` returns high, the first restart turn-on is visible RESTART_CYC+1 clock edges after the first edge that samples `en_i` high.
- R2: A trigger (`zcd_low_i` high) that was not preceded by an arming sample (`zcd_arm_i` high) does not start a cycle.
- R3: An armed trigger, with no stop condition, drives `gate_o` high at the clock edge that samples the trigger. The arming is used up by that trigger.
- R4: After a turn-on, `cs_ref_i` is ignored until the gate has been high for BLANK_CYC cycles. If `cs_ref_i` is held high from the turn-on, the pulse lasts exactly BLANK_CYC cycles.
- R5: After the blanking window, a `cs_ref_i` sample that is high ends the pulse at that same edge.
- R6: With no turn-off event, the gate stays high for exactly MAX_ON_CYC cycles.
- R7: With no demagnetisation edges, the restart timer turns the gate on every RESTART_CYC cycles. `restart_o` is high in the first gate-high cycle of each turn-on that the timer caused.
- R8: Every turn-on reloads the restart timer. After a demagnetisation-started turn-on, the next restart turn-on comes RESTART_CYC cycles later, and `restart_o` stays low for the demagnetisation-started pulse.
- R9: While `cs_stop_i` is high the gate goes or stays low from the next edge and `inhibit_o` is high. When it clears, a restart that is already due turns on at the first edge that samples it low.
- R10: While `ovp_i` is high the gate goes or stays low and `inhibit_o` is high. An armed trigger that arrives during this time is used up without a turn-on. Normal turn-on resumes once `ovp_i` clears.
- R11: `fbdis_o` is high one edge after `fb_low_i` and `ovp_i` are sampled high together, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable from the sequencer |
| zcd_arm_i | input | 1 | Demagnetisation sense above arming level |
| zcd_low_i | input | 1 | Demagnetisation sense below trigger level |
| cs_ref_i | input | 1 | Current sense above sinusoidal reference |
| cs_stop_i | input | 1 | Current sense above saturation stop level |
| ovp_i | input | 1 | Dynamic over-voltage on the output rail |
| fb_low_i | input | 1 | Feedback input below open-loop level |
| gate_o | output | 1 | Gate on request |
| restart_o | output | 1 | First cycle of a timer-started pulse |
| inhibit_o | output | 1 | A non-latched stop condition is active |
| fbdis_o | output | 1 | Feedback-disconnection fault flag |

## Verification
The bench sends a trigger with no prior arming and checks that no pulse follows. A detector that acted on the level alone would fire there. It holds the reference comparator high from the turn-on and checks that the pulse is exactly the blanking length, which catches a window that is one cycle off or missing. It measures the spacing of restart pulses after a demagnetisation-started turn-on. A timer that is not reloaded would give a short gap and a pulse right after the normal cycle. It sends an armed trigger during over-voltage and a restart that falls due during a saturation stop. These catch a design that latches the stop, replays the lost trigger later, or misses the restart once the stop clears.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
   typedef enum logic {SRC_ZCD = 1'b0, SRC_TIMER = 1'b1} on_src_e;

   function automatic int cnt_w(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/tmg_zcd_arm.sv
module tmg_zcd_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic arm_i,
   input  logic low_i,
   output logic evt_o
);
   logic armed_q;

   assign evt_o = armed_q & low_i & ~arm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (clr_i)    armed_q <= 1'b0;
      else if (arm_i)    armed_q <= 1'b1;
      else if (evt_o)    armed_q <= 1'b0;
   end

   // R2: with no arming stored or sampled, no trigger event can follow
   a_r2_trigger_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !arm_i) |=> !evt_o);
endmodule

// File: rtl/tmg_upcnt.sv
module tmg_upcnt #(
   parameter int MAX = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic load_i,
   input  logic inc_i,
   output logic [tmg_pkg::cnt_w(MAX)-1:0] cnt_o
);
   localparam int W = tmg_pkg::cnt_w(MAX);
   localparam logic [W-1:0] MAX_V = W'(MAX);

   initial begin : elab_chk
      assert (MAX >= 2) else $error("tmg_upcnt: MAX must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_o <= '0;
      else if (clr_i)                cnt_o <= '0;
      else if (load_i)               cnt_o <= W'(1);
      else if (inc_i && cnt_o != MAX_V) cnt_o <= cnt_o + 1'b1;
   end

   // R6/R7: a saturated count does not wrap unless reloaded or cleared
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == MAX_V && !clr_i && !load_i) |=> cnt_o == MAX_V);
endmodule

// File: rtl/tm_boost_gate_ctl.sv
module tm_boost_gate_ctl #(
   parameter int BLANK_CYC   = 10,
   parameter int MAX_ON_CYC  = 1000,
   parameter int RESTART_CYC = 3333,
   parameter bit FAST_KILL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic zcd_arm_i,
   input  logic zcd_low_i,
   input  logic cs_ref_i,
   input  logic cs_stop_i,
   input  logic ovp_i,
   input  logic fb_low_i,
   output logic gate_o,
   output logic restart_o,
   output logic inhibit_o,
   output logic fbdis_o
);
   import tmg_pkg::*;

   localparam int OW = cnt_w(MAX_ON_CYC);
   localparam int RW = cnt_w(RESTART_CYC);
   localparam logic [OW-1:0] BLANK_V = OW'(BLANK_CYC);
   localparam logic [OW-1:0] MAXON_V = OW'(MAX_ON_CYC);
   localparam logic [RW-1:0] RSTRT_V = RW'(RESTART_CYC);

   initial begin : elab_chk
      assert (BLANK_CYC >= 1) else $error("BLANK_CYC must be at least 1");
      assert (MAX_ON_CYC > BLANK_CYC) else $error("MAX_ON_CYC must exceed BLANK_CYC");
      assert (RESTART_CYC > MAX_ON_CYC) else $error("RESTART_CYC must exceed MAX_ON_CYC");
   end

   logic gate_q, restart_q, inhibit_q, fbdis_q;
   logic zcd_evt, inh, due, turn_on, turn_off;
   logic [OW-1:0] on_cnt;
   logic [RW-1:0] rs_cnt;
   on_src_e src;

   tmg_zcd_arm u_zcd (
      .clk(clk), .rst_n(rst_n), .clr_i(!en_i),
      .arm_i(zcd_arm_i), .low_i(zcd_low_i), .evt_o(zcd_evt)
   );

   tmg_upcnt #(.MAX(MAX_ON_CYC)) u_on_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(!en_i),
      .load_i(turn_on), .inc_i(gate_q), .cnt_o(on_cnt)
   );

   tmg_upcnt #(.MAX(RESTART_CYC)) u_rs_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(!en_i),
      .load_i(turn_on), .inc_i(1'b1), .cnt_o(rs_cnt)
   );

   assign inh      = ovp_i | cs_stop_i;
   assign due      = (rs_cnt >= RSTRT_V);
   assign src      = zcd_evt ? SRC_ZCD : SRC_TIMER;
   assign turn_on  = en_i && !gate_q && !inh && (zcd_evt || due);
   assign turn_off = gate_q && (!en_i || inh
                     || (on_cnt >= BLANK_V && cs_ref_i)
                     || (on_cnt >= MAXON_V));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         restart_q <= 1'b0;
         inhibit_q <= 1'b0;
         fbdis_q   <= 1'b0;
      end else begin
         if (turn_on)       gate_q <= 1'b1;
         else if (turn_off) gate_q <= 1'b0;
         restart_q <= turn_on && (src == SRC_TIMER);
         inhibit_q <= inh;
         fbdis_q   <= fb_low_i & ovp_i;
      end
   end

   generate
      if (FAST_KILL) begin : g_fast_kill
         assign gate_o = gate_q & ~inh & en_i;
      end else begin : g_reg_kill
         assign gate_o = gate_q;
      end
   endgenerate

   assign restart_o = restart_q;
   assign inhibit_o = inhibit_q;
   assign fbdis_o   = fbdis_q;

   // R1: disable forces the gate low and clears the on-time count
   a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!gate_q && on_cnt == '0));
   // R4: a pulse ends inside the blanking window only through a stop or disable
   a_r4_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_q) && $past(on_cnt) < BLANK_V) |-> ($past(inh) || !$past(en_i)));
   // R6: a pulse never outlives the maximum on-time
   a_r6_max_on: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && on_cnt == MAXON_V) |=> !gate_q);
   // R7: the timer-start flag only accompanies a gate pulse
   a_r7_flag_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |-> gate_q);
   // R9: saturation stop takes the gate low
   a_r9_stop_kills: assert property (@(posedge clk) disable iff (!rst_n)
      cs_stop_i |=> !gate_q);
   // R10: over-voltage takes the gate low
   a_r10_ovp_kills: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_i |=> !gate_q);
endmodule

// File: tb/test_tm_boost_gate_ctl.sv
`timescale 1ns/1ps
module test_tm_boost_gate_ctl;
   localparam int BLANK = 10;
   localparam int MAXON = 1000;
   localparam int RSTRT = 3333;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic arm = 1'b0, low = 1'b0, csr = 1'b0, css = 1'b0, ovp = 1'b0, fbl = 1'b0;
   logic gate, rstf, inh, fbd;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   tm_boost_gate_ctl #(.BLANK_CYC(BLANK), .MAX_ON_CYC(MAXON), .RESTART_CYC(RSTRT))
   i_tm_boost_gate_ctl (
      .clk(clk), .rst_n(rst_n), .en_i(en), .zcd_arm_i(arm), .zcd_low_i(low),
      .cs_ref_i(csr), .cs_stop_i(css), .ovp_i(ovp), .fb_low_i(fbl),
      .gate_o(gate), .restart_o(rstf), .inhibit_o(inh), .fbdis_o(fbd)
   );

   // inputs {arm,low,csr,css,ovp,fbl} then expected {gate,inhibit,fbdis}
   localparam logic [8:0] VEC [0:15] = '{
      9'b000000_000, 9'b010000_000, 9'b100000_000, 9'b010000_100,
      9'b000000_100, 9'b000100_010, 9'b000000_000, 9'b100000_000,
      9'b000010_010, 9'b010010_010, 9'b000011_011, 9'b000001_000,
      9'b100000_000, 9'b010000_100, 9'b000010_010, 9'b000000_000
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_rise(output int n);
      logic prev;
      n = 0;
      prev = gate;
      for (int i = 0; i < 20000; i++) begin
         tick();
         n++;
         if (gate && !prev) break;
         prev = gate;
      end
   endtask

   task automatic zcd_on();
      arm = 1'b1; tick();
      arm = 1'b0; low = 1'b1; tick();
      low = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n, cnt;
      tick(); tick();
      // R1: reset state
      chk("R1 reset gate", gate, 0);
      chk("R1 reset restart", rstf, 0);
      chk("R1 reset inhibit", inh, 0);
      chk("R1 reset fbdis", fbd, 0);
      rst_n = 1'b1; tick();
      chk("R1 disabled gate", gate, 0);
      en = 1'b1;

      // table: R2 R3 R9 R10 R11
      for (int i = 0; i < 16; i++) begin
         {arm, low, csr, css, ovp, fbl} = VEC[i][8:3];
         tick();
         chk($sformatf("R2/R3/R9/R10/R11 vec%0d gate", i), gate, int'(VEC[i][2]));
         chk($sformatf("R9/R10 vec%0d inhibit", i), inh, int'(VEC[i][1]));
         chk($sformatf("R11 vec%0d fbdis", i), fbd, int'(VEC[i][0]));
      end
      {arm, low, csr, css, ovp, fbl} = '0;
      tick();

      // R4: reference held high from turn-on
      zcd_on();
      csr = 1'b1;
      cnt = 1;
      for (int i = 0; i < 2 * MAXON; i++) begin
         tick();
         if (!gate) break;
         cnt++;
      end
      chk("R4 blanked pulse length", cnt, BLANK);
      csr = 1'b0; tick();

      // R5: reference after blanking ends the pulse at once
      zcd_on();
      repeat (30) tick();
      chk("R5 still high before ref", gate, 1);
      csr = 1'b1; tick();
      chk("R5 ref ends pulse", gate, 0);
      csr = 1'b0; tick();

      // R6: maximum on-time
      zcd_on();
      cnt = 1;
      for (int i = 0; i < 2 * MAXON; i++) begin
         tick();
         if (!gate) break;
         cnt++;
      end
      chk("R6 max on length", cnt, MAXON);
      tick();

      // R1: disable mid pulse, then restart timing after enable
      zcd_on();
      en = 1'b0; tick();
      chk("R1 disable drops gate", gate, 0);
      repeat (5) tick();
      csr = 1'b1;
      en = 1'b1;
      wait_rise(n);
      chk("R1 first restart after enable", n, RSTRT + 1);
      chk("R7 restart flag on timer start", rstf, 1);

      // R7: restart period
      wait_rise(n);
      chk("R7 restart period", n, RSTRT);
      chk("R7 restart flag second", rstf, 1);

      // R8: reload on demagnetisation turn-on
      repeat (200) tick();
      zcd_on();
      chk("R8 zcd turn-on", gate, 1);
      chk("R8 no restart flag on zcd start", rstf, 0);
      wait_rise(n);
      chk("R8 restart spacing after zcd", n, RSTRT);
      chk("R8 restart flag after reload", rstf, 1);

      // R9: stop held past restart due time, then resume
      css = 1'b1;
      cnt = 0;
      for (int i = 0; i < RSTRT + 50; i++) begin
         tick();
         if (gate) cnt++;
      end
      chk("R9 gate held low under stop", cnt, 0);
      chk("R9 inhibit under stop", inh, 1);
      css = 1'b0; tick();
      chk("R9 resume after stop", gate, 1);
      chk("R9 inhibit cleared", inh, 0);
      chk("R9 resume flagged as restart", rstf, 1);
      csr = 1'b0;
      tick();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule